// File: doc/BRIEF.md
# Interrupt Request Masking and Routing Bank

This block gathers a set of level-sensitive interrupt request lines, merges them with requests that software raises through registers, and sends every source down one of two paths. A per-source routing select puts a source on the fast path, where no enable mask applies. Sources left on the normal path are gated by a per-source enable. The fast path drives a single fast interrupt line. The masked normal-path vector goes on to a separate vector and priority unit.

Software reaches the block through a simple word-addressed port that has a combinational read. Enables and software requests each have their own set and clear words, so updating one source never needs a read-modify-write. The port also gives read-only views of the raw, normal and fast request vectors, holds a one-bit protection flag, and exposes an eight-word identification window. Hardware inputs pass through a two-stage synchronizer before they are merged.

Top module: `irq_route_bank`

## Requirements
- R1: The raw request vector at word 0x02 is the bitwise OR of the synchronized hardware inputs and the software request register.
- R2: The normal status at word 0x00 and the output `norm_req_o` are both equal to raw AND enable AND NOT select. A source that is routed fast never appears on the normal path.
- R3: The fast status at word 0x01 is raw AND select, with no enable applied. `fast_irq_o` is high exactly when any bit of it is set.
- R4: The routing select register at word 0x03 reads back the last value written to it.
- R5: A write to word 0x04 ORs the data into the enable register. A write to word 0x05 clears the enable bits that are set in the data. Word 0x04 reads the enable register.
- R6: A write to word 0x06 ORs the data into the software request register. A write to word 0x07 clears the bits that are set in the data. Word 0x06 reads the software request register.
- R7: Word 0x08 stores only data bit 0 as the protection flag and reads it back in bit 0. All other bits read as zero.
- R8: Writes to the read-only status words 0x00, 0x01 and 0x02 change no register and no output.
- R9: Words 0x3F8 through 0x3FF read the identification bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended to the full word.
- R10: After reset the enable, select, software request and protection registers are zero, and both outputs are low.
- R11: A change on a hardware input shows in raw status two clock edges after it is applied, and not after only one.
- R12: A read of any unmapped word returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_in | input | NSRC | Hardware interrupt request levels |
| addr_i | input | AW | Word address of the register port |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | DW | Write data |
| rd_data_o | output | DW | Combinational read data for `addr_i` |
| fast_irq_o | output | 1 | Fast interrupt line |
| norm_req_o | output | NSRC | Masked normal-path request vector for the vector unit |

## Verification
The assertions check the set and clear algebra of the enable and software registers on every write cycle. They also check the select and protection stores, confirm that writes to status words leave every register stable, and confirm that the normal vector never overlaps the select mask and never shows a disabled source. The bench scenarios are needed for what depends on the whole datapath. This covers the routing results under several enable and select patterns, with a single hardware or software source walked across all positions. It also covers the two-edge synchronizer latency, the identification bytes and the zero returned for unmapped words.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned W_NORM_STAT = 10'h000;
  localparam int unsigned W_FAST_STAT = 10'h001;
  localparam int unsigned W_RAW_STAT  = 10'h002;
  localparam int unsigned W_ROUTE_SEL = 10'h003;
  localparam int unsigned W_EN_SET    = 10'h004;
  localparam int unsigned W_EN_CLR    = 10'h005;
  localparam int unsigned W_SW_SET    = 10'h006;
  localparam int unsigned W_SW_CLR    = 10'h007;
  localparam int unsigned W_PROT      = 10'h008;
  localparam int unsigned W_ID_BASE   = 10'h3F8;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0:    id_byte = 8'h90;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] d_in,
  output logic [NSRC-1:0] d_sync
);
  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_in[g];
        stab_q <= meta_q;
      end
    end
    assign d_sync[g] = stab_q;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 10,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] sel_q,
  output logic [NSRC-1:0] soft_q,
  output logic            prot_q
);
  logic [NSRC-1:0] wbits;
  logic [NSRC-1:0] en_d, sel_d, soft_d;
  logic            prot_d;
  logic            en_ce, sel_ce, soft_ce, prot_ce;

  assign wbits = wr_data_i[NSRC-1:0];

  always_comb begin
    en_d    = en_q;
    sel_d   = sel_q;
    soft_d  = soft_q;
    prot_d  = prot_q;
    en_ce   = 1'b0;
    sel_ce  = 1'b0;
    soft_ce = 1'b0;
    prot_ce = 1'b0;
    if (wr_en_i) begin
      case (int'(addr_i))
        W_ROUTE_SEL: begin sel_d  = wbits;           sel_ce  = 1'b1; end
        W_EN_SET:    begin en_d   = en_q | wbits;    en_ce   = 1'b1; end
        W_EN_CLR:    begin en_d   = en_q & ~wbits;   en_ce   = 1'b1; end
        W_SW_SET:    begin soft_d = soft_q | wbits;  soft_ce = 1'b1; end
        W_SW_CLR:    begin soft_d = soft_q & ~wbits; soft_ce = 1'b1; end
        W_PROT:      begin prot_d = wr_data_i[0];    prot_ce = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      soft_q <= '0;
      prot_q <= 1'b0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (sel_ce)  sel_q  <= sel_d;
      if (soft_ce) soft_q <= soft_d;
      if (prot_ce) prot_q <= prot_d;
    end
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(addr_i) == W_EN_SET) |=> en_q == ($past(en_q) | $past(wbits))); // R5
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(addr_i) == W_EN_CLR) |=> en_q == ($past(en_q) & ~$past(wbits))); // R5
  AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(addr_i) == W_SW_SET) |=> soft_q == ($past(soft_q) | $past(wbits))); // R6
  AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(addr_i) == W_SW_CLR) |=> soft_q == ($past(soft_q) & ~$past(wbits))); // R6
  AST_SEL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(addr_i) == W_ROUTE_SEL) |=> sel_q == $past(wbits)); // R4
  AST_PROT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(addr_i) == W_PROT) |=> prot_q == $past(wr_data_i[0])); // R7
  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(addr_i) <= W_RAW_STAT) |=>
      ($stable(en_q) && $stable(sel_q) && $stable(soft_q) && $stable(prot_q))); // R8
endmodule

// File: rtl/irq_readmux.sv
module irq_readmux
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 10,
  parameter int DW   = 32
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] norm_stat,
  input  logic [NSRC-1:0] fast_stat,
  input  logic [NSRC-1:0] raw_stat,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] sel_q,
  input  logic [NSRC-1:0] soft_q,
  input  logic            prot_q,
  output logic [DW-1:0]   rd_data_o
);
  localparam int unsigned ID_WORDS = 8;

  always_comb begin
    rd_data_o = '0;
    if (int'(addr_i) >= W_ID_BASE && int'(addr_i) < W_ID_BASE + ID_WORDS) begin
      rd_data_o = DW'(id_byte(addr_i[2:0]));
    end else begin
      case (int'(addr_i))
        W_NORM_STAT: rd_data_o = DW'(norm_stat);
        W_FAST_STAT: rd_data_o = DW'(fast_stat);
        W_RAW_STAT:  rd_data_o = DW'(raw_stat);
        W_ROUTE_SEL: rd_data_o = DW'(sel_q);
        W_EN_SET:    rd_data_o = DW'(en_q);
        W_SW_SET:    rd_data_o = DW'(soft_q);
        W_PROT:      rd_data_o = DW'(prot_q);
        default:     rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank #(
  parameter int NSRC = 32,
  parameter int AW   = 10,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_in,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            fast_irq_o,
  output logic [NSRC-1:0] norm_req_o
);
  logic            rst_n_sync;
  logic [NSRC-1:0] hw_sync;
  logic [NSRC-1:0] en_q, sel_q, soft_q;
  logic            prot_q;
  logic [NSRC-1:0] raw_req, norm_stat, fast_stat;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  irq_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n_sync), .d_in(req_in), .d_sync(hw_sync)
  );

  irq_regs #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .en_q(en_q), .sel_q(sel_q), .soft_q(soft_q),
    .prot_q(prot_q)
  );

  assign raw_req   = hw_sync | soft_q;
  assign norm_stat = raw_req & en_q & ~sel_q;
  assign fast_stat = raw_req & sel_q;

  irq_readmux #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_rd (
    .addr_i(addr_i), .norm_stat(norm_stat), .fast_stat(fast_stat),
    .raw_stat(raw_req), .en_q(en_q), .sel_q(sel_q), .soft_q(soft_q),
    .prot_q(prot_q), .rd_data_o(rd_data_o)
  );

  assign fast_irq_o = |fast_stat;
  assign norm_req_o = norm_stat;

  AST_NORM_NOT_FAST: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (norm_req_o & sel_q) == '0); // R2
  AST_NORM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (norm_req_o & ~en_q) == '0); // R2
  AST_FAST_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n_sync)
    fast_irq_o |-> (sel_q != '0)); // R3
endmodule

// File: tb/irq_route_bank_bench.sv
`timescale 1ns/1ps
module irq_route_bank_bench;
  localparam int NSRC = 32;
  localparam int AW   = 10;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] req_in;
  logic [AW-1:0]   addr_i;
  logic            wr_en_i;
  logic [DW-1:0]   wr_data_i;
  logic [DW-1:0]   rd_data_o;
  logic            fast_irq_o;
  logic [NSRC-1:0] norm_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_en, m_sel, m_soft, m_hw;

  always #2 clk = ~clk;

  irq_route_bank #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_irq_route_bank (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .fast_irq_o(fast_irq_o), .norm_req_o(norm_req_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr_i = AW'(a); wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr_i = AW'(a);
    #0.5;
    d = rd_data_o;
  endtask

  task automatic set_hw(input logic [31:0] v);
    @(negedge clk);
    req_in = v; m_hw = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [31:0] v, raw;
    raw = m_hw | m_soft;
    rd(32'h000, v); check("R2 normal status", v, raw & m_en & ~m_sel);
    check("R2 norm_req_o", norm_req_o, raw & m_en & ~m_sel);
    rd(32'h001, v); check("R3 fast status", v, raw & m_sel);
    check("R3 fast_irq_o", {31'd0, fast_irq_o}, {31'd0, |(raw & m_sel)});
    rd(32'h002, v); check("R1 raw status", v, raw);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] en_pat [4];
    logic [31:0] sel_pat [4];
    en_pat  = '{32'hFFFF_FFFF, 32'h5555_5555, 32'h0000_0000, 32'hF0F0_3C3C};
    sel_pat = '{32'h0000_0000, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'h8001_FF00};
    rst_n = 1'b0; req_in = '0; addr_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
    m_en = '0; m_sel = '0; m_soft = '0; m_hw = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    rd(32'h004, v); check("R10 enable reset", v, 0);
    rd(32'h003, v); check("R10 select reset", v, 0);
    rd(32'h006, v); check("R10 soft reset", v, 0);
    rd(32'h008, v); check("R10 protect reset", v, 0);
    check("R10 fast_irq_o reset", {31'd0, fast_irq_o}, 0);
    check("R10 norm_req_o reset", norm_req_o, 0);

    // R9 identification window
    for (int k = 0; k < 8; k++) begin
      logic [7:0] idb [8];
      idb = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      rd(32'h3F8 + k, v); check("R9 id byte", v, {24'd0, idb[k]});
    end

    // R12 unmapped words
    rd(32'h005, v); check("R12 unmapped 0x05", v, 0);
    rd(32'h007, v); check("R12 unmapped 0x07", v, 0);
    rd(32'h009, v); check("R12 unmapped 0x09", v, 0);
    rd(32'h100, v); check("R12 unmapped 0x100", v, 0);
    rd(32'h3F7, v); check("R12 unmapped 0x3F7", v, 0);

    // R7 protection flag
    wr(32'h008, 32'hFFFF_FFFF); rd(32'h008, v); check("R7 protect set", v, 1);
    wr(32'h008, 32'hFFFF_FFFE); rd(32'h008, v); check("R7 protect clear", v, 0);

    // R4 select readback
    wr(32'h003, 32'hA5C3_0F81); rd(32'h003, v); check("R4 select", v, 32'hA5C3_0F81);
    wr(32'h003, 32'h0); rd(32'h003, v); check("R4 select zero", v, 0);

    // R5 enable set/clear
    wr(32'h004, 32'h0000_00F0); wr(32'h004, 32'h0F00_0001);
    rd(32'h004, v); check("R5 enable set accumulates", v, 32'h0F00_00F1);
    wr(32'h005, 32'h0100_0030);
    rd(32'h004, v); check("R5 enable clear", v, 32'h0E00_00C1);
    wr(32'h005, 32'hFFFF_FFFF);
    rd(32'h004, v); check("R5 enable clear all", v, 0);

    // R6 software set/clear
    wr(32'h006, 32'h8000_0003); wr(32'h006, 32'h0000_0300);
    rd(32'h006, v); check("R6 soft set accumulates", v, 32'h8000_0303);
    wr(32'h007, 32'h8000_0101);
    rd(32'h006, v); check("R6 soft clear", v, 32'h0000_0202);
    wr(32'h007, 32'hFFFF_FFFF);
    rd(32'h006, v); check("R6 soft clear all", v, 0);

    // R11 synchronizer latency
    @(negedge clk); req_in = 32'h0000_0400;
    @(negedge clk); rd(32'h002, v); check("R11 not after one edge", v, 0);
    @(negedge clk); rd(32'h002, v); check("R11 after two edges", v, 32'h0000_0400);
    m_hw = 32'h0000_0400;
    set_hw(32'h0);

    // R1 R2 R3 sweep: walking hardware and software sources under routing patterns
    for (int p = 0; p < 4; p++) begin
      wr(32'h005, 32'hFFFF_FFFF); wr(32'h004, en_pat[p]); m_en = en_pat[p];
      wr(32'h003, sel_pat[p]); m_sel = sel_pat[p];
      for (int i = 0; i < NSRC; i++) begin
        set_hw(32'd1 << i);
        check_all();
        set_hw(32'h0);
        wr(32'h006, 32'd1 << i); m_soft = 32'd1 << i;
        check_all();
        wr(32'h007, 32'd1 << i); m_soft = 0;
      end
      set_hw(32'h1234_8421); wr(32'h006, 32'h4100_0010); m_soft = 32'h4100_0010;
      check_all();
      wr(32'h007, 32'hFFFF_FFFF); m_soft = 0; set_hw(32'h0);
    end

    // R8 writes to status words ignored
    wr(32'h004, 32'h0000_FFFF); m_en = 32'hF0F0_FFFF;
    wr(32'h003, 32'h00FF_0000); m_sel = 32'h00FF_0000;
    wr(32'h006, 32'h0101_0101); m_soft = 32'h0101_0101;
    set_hw(32'h0010_0010);
    for (int a = 0; a < 3; a++) begin
      wr(a, 32'hFFFF_FFFF);
      rd(32'h004, v); check("R8 enable unchanged", v, m_en);
      rd(32'h003, v); check("R8 select unchanged", v, m_sel);
      rd(32'h006, v); check("R8 soft unchanged", v, m_soft);
      rd(32'h008, v); check("R8 protect unchanged", v, 0);
      check_all();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule